// File: doc/BRIEF.md
# Packed SIMD Minimum/Maximum Unit

This execution unit compares the lanes of a 256-bit vector. It takes a 32-bit instruction word, a first source vector and a second source vector. In each lane it returns either the smaller or the larger of the two elements. The instruction chooses the lane width (8, 16, 32 or 64 bits), whether the comparison is signed or unsigned, and whether the result is the minimum or the maximum.

An immediate form replaces the second source vector with a 5-bit constant. That constant comes from the instruction word, is extended to the lane width and is applied to every lane. The register file, issue logic and other vector operations sit outside this block.

The issuing stage drives the instruction word and both operand values together with a one-cycle valid strobe. Exactly one clock edge later the unit presents the registered result, the destination register index and a completion pulse. An illegal flag is raised alongside the completion pulse when the instruction word does not decode.

Top module: `simd_minmax_unit`

## Requirements
- R1: While rst_ni is low, and right after it is released, result_o, dest_o, done_o and illegal_o are all zero.
- R2: done_o is high for exactly the one cycle that follows each cycle in which valid_i is high. It stays low otherwise.
- R3: A register-register operation has bits [31:20] equal to 0111_0100_0111. Bits [19:15] are the operation code. Bits [16:15] select the lane width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Bits [14:10] hold the second source index, which is not used here because the operand value arrives on src_b_i.
- R4: Bit 18 set selects an unsigned comparison. Bit 18 clear selects a two's-complement signed comparison. This applies to every lane width.
- R5: Bit 17 set selects minimum: a lane takes the src_a_i element when it is strictly less than the second operand, and the second operand otherwise. Bit 17 clear selects maximum: a lane takes the src_a_i element when it is strictly greater, and the second operand otherwise.
- R6: A register-immediate operation has bits [31:20] equal to 0111_0110_1001. It uses the same operation-code fields as R3. Its second operand in every lane is bits [14:10], sign-extended when the operation is signed and zero-extended when it is unsigned. src_b_i has no effect in this form.
- R7: After an accepted legal operation, dest_o equals bits [4:0] of that instruction word.
- R8: An instruction word is illegal when it matches neither upper pattern or when bit 19 is set. For an illegal word, illegal_o is high together with done_o, and result_o and dest_o keep their previous values.
- R9: Lanes are computed independently. The 256-bit vector holds 32, 16, 8 or 4 lanes, with lane i occupying bits [i*W+W-1 : i*W].
- R10: result_o and dest_o change only on a cycle in which done_o is high with illegal_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe, one cycle per operation |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 256 | First source vector |
| src_b_i | input | 256 | Second source vector (register form) |
| result_o | output | 256 | Registered lane-wise result |
| dest_o | output | 5 | Registered destination register index |
| done_o | output | 1 | Completion pulse, one cycle after valid_i |
| illegal_o | output | 1 | Decode failure, valid together with done_o |

## Verification
The result, the destination index, the completion pulse and the illegal flag are all due on the first rising edge after the cycle in which valid_i is high. Nothing takes longer. The bench drives each operation on a falling edge and drops valid_i on the next falling edge. At that point it samples all four outputs, half a period after the edge that loaded them. Idle cycles and illegal words are checked at the same point against the value held from the last legal operation, which shows that the held state did not move.

// File: rtl/simd_minmax_pkg.sv
package simd_minmax_pkg;
  localparam int unsigned VLEN    = 256;
  localparam int unsigned ILEN    = 32;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned IMM_W   = 5;
  localparam int unsigned NUM_WID = 4;

  localparam logic [11:0] MAJOR_RR = 12'b0111_0100_0111;
  localparam logic [11:0] MAJOR_RI = 12'b0111_0110_1001;

  typedef enum logic [1:0] {
    LW_8  = 2'b00,
    LW_16 = 2'b01,
    LW_32 = 2'b10,
    LW_64 = 2'b11
  } lane_w_e;

  typedef struct packed {
    logic              legal;
    logic              imm_form;
    logic              is_min;
    logic              is_uns;
    lane_w_e           width;
    logic [IMM_W-1:0]  imm;
    logic [RIDX_W-1:0] dest;
  } mm_op_t;
endpackage

// File: rtl/simd_minmax_dec.sv
module simd_minmax_dec
  import simd_minmax_pkg::*;
(
  input  logic [11:0]       major_i,
  input  logic [4:0]        subop_i,
  input  logic [IMM_W-1:0]  field_k_i,
  input  logic [RIDX_W-1:0] dest_i,
  output mm_op_t            op_o
);
  logic is_rr, is_ri;

  always_comb begin
    is_rr        = (major_i == MAJOR_RR);
    is_ri        = (major_i == MAJOR_RI);
    op_o.legal    = (is_rr | is_ri) & ~subop_i[4];
    op_o.imm_form = is_ri;
    op_o.is_min   = subop_i[2];
    op_o.is_uns   = subop_i[3];
    op_o.width    = lane_w_e'(subop_i[1:0]);
    op_o.imm      = field_k_i;
    op_o.dest     = dest_i;
  end
endmodule

// File: rtl/simd_minmax_lanes.sv
module simd_minmax_lanes #(
  parameter int unsigned VLEN  = 256,
  parameter int unsigned LW    = 8,
  parameter int unsigned IMM_W = 5
) (
  input  logic [VLEN-1:0]  a_i,
  input  logic [VLEN-1:0]  b_i,
  input  logic             imm_form_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             is_min_i,
  input  logic             is_uns_i,
  output logic [VLEN-1:0]  res_o
);
  localparam int unsigned NL = VLEN / LW;

  logic [LW-1:0] imm_ext;
  logic [LW-1:0] sflip;

  always_comb begin
    imm_ext = is_uns_i ? LW'(imm_i) : {{(LW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    sflip   = {~is_uns_i, {(LW-1){1'b0}}};
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] x, y, xk, yk;
    logic          lt, gt;
    always_comb begin
      x  = a_i[l*LW +: LW];
      y  = imm_form_i ? imm_ext : b_i[l*LW +: LW];
      // offset-binary trick: flipping the sign bit maps signed order onto unsigned
      xk = x ^ sflip;
      yk = y ^ sflip;
      lt = xk < yk;
      gt = xk > yk;
      res_o[l*LW +: LW] = is_min_i ? (lt ? x : y) : (gt ? x : y);
    end
  end
endmodule

// File: rtl/simd_minmax_unit.sv
module simd_minmax_unit
  import simd_minmax_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ILEN-1:0]   instr_i,
  input  logic [VLEN-1:0]   src_a_i,
  input  logic [VLEN-1:0]   src_b_i,
  output logic [VLEN-1:0]   result_o,
  output logic [RIDX_W-1:0] dest_o,
  output logic              done_o,
  output logic              illegal_o
);
  mm_op_t          op;
  logic [VLEN-1:0] res_w [NUM_WID];
  logic [VLEN-1:0] res_sel;

  simd_minmax_dec u_dec (
    .major_i   (instr_i[31:20]),
    .subop_i   (instr_i[19:15]),
    .field_k_i (instr_i[14:10]),
    .dest_i    (instr_i[4:0]),
    .op_o      (op)
  );

  for (genvar g = 0; g < NUM_WID; g++) begin : g_wid
    simd_minmax_lanes #(
      .VLEN  (VLEN),
      .LW    (8 << g),
      .IMM_W (IMM_W)
    ) u_lanes (
      .a_i        (src_a_i),
      .b_i        (src_b_i),
      .imm_form_i (op.imm_form),
      .imm_i      (op.imm),
      .is_min_i   (op.is_min),
      .is_uns_i   (op.is_uns),
      .res_o      (res_w[g])
    );
  end

  always_comb res_sel = res_w[op.width];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      dest_o    <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= valid_i;
      illegal_o <= valid_i & ~op.legal;
      if (valid_i && op.legal) begin
        result_o <= res_sel;
        dest_o   <= op.dest;
      end
    end
  end
endmodule

// File: rtl/simd_minmax_chk.sv
module simd_minmax_chk
  import simd_minmax_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [VLEN-1:0]   result_o,
  input logic [RIDX_W-1:0] dest_o,
  input logic              done_o,
  input logic              illegal_o
);
  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (done_o == 1'b0 && illegal_o == 1'b0 && result_o == '0 && dest_o == '0)
        else $error("reset state wrong");
    end
  end

  p_done_after_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  p_no_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  p_illegal_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o);

  p_illegal_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(result_o) && $stable(dest_o)));

  p_idle_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(dest_o)));
endmodule

bind simd_minmax_unit simd_minmax_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .result_o  (result_o),
  .dest_o    (dest_o),
  .done_o    (done_o),
  .illegal_o (illegal_o)
);

// File: tb/simd_minmax_unit_tb.sv
module simd_minmax_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] RR = 12'b0111_0100_0111;
  localparam logic [11:0] RI = 12'b0111_0110_1001;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [255:0] src_a_i = '0, src_b_i = '0;
  logic [255:0] result_o;
  logic [4:0]   dest_o;
  logic         done_o, illegal_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [255:0] exp_res = '0;
  logic [4:0]   exp_dst = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_minmax_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .result_o(result_o),
    .dest_o(dest_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  function automatic logic [255:0] ref_op(logic [31:0] ins, logic [255:0] a, logic [255:0] b);
    int w;
    logic [63:0] mask, x, y, xs, ys, r, sb;
    logic [255:0] res;
    w    = 8 << ins[16:15];
    mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    sb   = ins[18] ? 64'd0 : (64'd1 << (w - 1));
    res  = '0;
    for (int i = 0; i < 256 / w; i++) begin
      x = 64'(a >> (i * w)) & mask;
      if (ins[31:20] == RI)
        y = (ins[18] ? {59'd0, ins[14:10]} : {{59{ins[14]}}, ins[14:10]}) & mask;
      else
        y = 64'(b >> (i * w)) & mask;
      xs = x ^ sb;
      ys = y ^ sb;
      if (ins[17]) r = (xs < ys) ? x : y;
      else         r = (xs > ys) ? x : y;
      res = res | (256'(r) << (i * w));
    end
    return res;
  endfunction

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] ins, logic [255:0] a, logic [255:0] b, string req);
    bit legal;
    legal = ((ins[31:20] == RR) || (ins[31:20] == RI)) && !ins[19];
    @(negedge clk);
    valid_i = 1'b1; instr_i = ins; src_a_i = a; src_b_i = b;
    @(negedge clk);
    valid_i = 1'b0;
    if (legal) begin
      exp_res = ref_op(ins, a, b);
      exp_dst = ins[4:0];
    end
    chk(done_o == 1'b1, {req, " done"}, 256'(done_o), 256'd1);
    chk(illegal_o == !legal, {req, " illegal"}, 256'(illegal_o), 256'(!legal));
    chk(result_o == exp_res, {req, " result"}, result_o, exp_res);
    chk(dest_o == exp_dst, {req, " R7 dest"}, 256'(dest_o), 256'(exp_dst));
  endtask

  function automatic logic [31:0] mk(logic [11:0] maj, logic [4:0] sub, logic [4:0] k, logic [4:0] d);
    return {maj, sub, k, 5'(d + 5'd3), d};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [255:0] pat [5];
    logic [4:0]   imms [4];
    logic [255:0] ra, rb;
    logic [31:0]  ri;
    void'($urandom(32'h5EED_1234));
    pat[0] = {32{8'h80}};
    pat[1] = {32{8'h7F}};
    pat[2] = '0;
    pat[3] = '1;
    pat[4] = {4{64'h8000_0000_7FFF_FF01}};
    imms[0] = 5'h10; imms[1] = 5'h0F; imms[2] = 5'h00; imms[3] = 5'h1F;

    repeat (3) @(negedge clk);
    chk(result_o == '0 && dest_o == '0 && !done_o && !illegal_o, "R1 reset", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(result_o == '0 && !done_o, "R1 after release", result_o, '0);

    // directed register-register: every subop x boundary pairs (R3 R4 R5 R9)
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          issue(mk(RR, 5'(s), 5'(i + j), 5'(s + i)), pat[i], {pat[j][127:0], pat[(j+1)%5][127:0]},
                "R3 R4 R5 R9 rr");

    // directed immediate: -16, +15, 0, -1/31; src_b ignored (R6)
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 5; i++)
        for (int k = 0; k < 4; k++)
          issue(mk(RI, 5'(s), imms[k], 5'(k)), pat[i], {8{$urandom}}, "R6 imm");

    // idle cycle: no pulse, state held (R2 R10)
    @(negedge clk);
    chk(!done_o, "R2 idle", 256'(done_o), 256'd0);
    chk(result_o == exp_res, "R10 idle hold", result_o, exp_res);

    // illegal words (R8)
    issue({RR, 5'b10000, 15'h1234}, pat[1], pat[0], "R8 bit19");
    issue({RI, 5'b11101, 15'h0042}, pat[3], pat[2], "R8 bit19 imm");
    issue({12'hABC, 5'b00001, 15'h7777}, pat[0], pat[1], "R8 major");
    issue({12'b0111_0100_0110, 5'b00100, 15'h0001}, pat[2], pat[3], "R8 near-major");

    // back-to-back strobes (R2)
    @(negedge clk);
    valid_i = 1'b1; instr_i = mk(RR, 5'b00101, 5'd0, 5'd9); src_a_i = pat[4]; src_b_i = pat[2];
    @(negedge clk);
    exp_res = ref_op(instr_i, src_a_i, src_b_i); exp_dst = 5'd9;
    chk(done_o && result_o == exp_res, "R2 b2b first", result_o, exp_res);
    instr_i = mk(RI, 5'b01011, 5'h15, 5'd17); src_a_i = pat[3];
    @(negedge clk);
    valid_i = 1'b0;
    exp_res = ref_op(instr_i, src_a_i, src_b_i); exp_dst = 5'd17;
    chk(done_o && result_o == exp_res && dest_o == exp_dst, "R2 b2b second", result_o, exp_res);
    @(negedge clk);
    chk(!done_o, "R2 pulse ends", 256'(done_o), 256'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      ra = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      ri = $urandom;
      ri[31:20] = ri[0] ? RI : RR;
      if (($urandom % 8) != 0) ri[19] = 1'b0;
      if (($urandom % 4) == 0) ra[63:0] = rb[63:0];
      issue(ri, ra, rb, "R4 R5 R6 random");
    end

    finish_run();
  end
endmodule